// File: doc/BRIEF.md
# Doubleword Data Memory with Sub-Word Store Merge

This block is the data memory of a small 64-bit processor datapath. It holds 128 cells of 64 bits, 1024 bytes in all. The address adder supplies a 64-bit byte address. Bits [9:3] of that address select the cell. The low three bits locate a byte or word inside the cell.

The storage array can only write whole cells. A byte or word store therefore reads the addressed cell within the same cycle. It then replaces only the selected lanes with the new data and writes the merged cell back on the rising clock edge, so every byte outside the store keeps its value. A doubleword store writes the whole input value.

The output is the raw contents of the addressed cell, gated by the load enable. Picking a field out of the loaded cell and sign-extending it is left to the consumer.

Top module: `dw_store_ram`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears every cell to zero.
- R2: The cell index is byte_addr[9:3]. Address bits 63..10 have no effect, so two addresses that differ only there reach the same cell.
- R3: With st_en high and size_code 2'b11 (doubleword), the whole 64-bit st_data is written into the cell at the next rising edge. byte_addr[2:0] is ignored.
- R4: With st_en high and size_code 2'b10 (word), byte_addr[2] picks the half. When it is 0, the cell becomes {old bits 63:32, st_data[31:0]}. When it is 1, the cell becomes {st_data[31:0], old bits 31:0}.
- R5: With st_en high and size_code 2'b00 (byte), byte lane byte_addr[2:0] (lane n is bits 8n+7..8n) receives st_data[7:0]. The other seven lanes keep their old values.
- R6: size_code 2'b01 is not supported. A store with that code leaves the memory unchanged.
- R7: With st_en low, no cell changes, whatever the other inputs are.
- R8: The read is combinational. rd_data shows the addressed cell in the same cycle, and a store becomes visible only after its clock edge. A load in the same cycle as a store returns the old contents.
- R9: With ld_en low, rd_data is zero. A sub-word store still merges against the stored cell contents even when ld_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the array |
| byte_addr | input | 64 | Byte address from the address adder |
| st_data | input | 64 | Store value; its low bits are used for word and byte stores |
| ld_en | input | 1 | Load enable; gates rd_data |
| st_en | input | 1 | Store enable |
| size_code | input | 2 | 00 byte, 01 unsupported, 10 word, 11 doubleword |
| rd_data | output | 64 | Addressed cell contents, or zero when ld_en is low |

## Verification
The bench builds the block with its default parameters: 128 cells of 64 bits and a 64-bit address. The array is small, so random stores confined to a handful of cells pile byte, word and doubleword stores onto the same cell. This exposes any lane that a merge corrupts. The full 64-bit address lets random upper bits show the aliasing above bit 9. Directed cases walk all eight byte lanes, both word halves, the unsupported size code, a store with ld_en low and the clearing of the array by reset.

// File: rtl/ramst_pkg.sv
// Shared types for the doubleword store-merge memory.
// Assumes the size code is taken from the low two bits of the store funct3.
package ramst_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,   // not supported: never writes
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } size_t;
endpackage

// File: rtl/ramst_addr_split.sv
// Splits a byte address into a cell index and an in-cell byte offset.
// Assumes ADDR_W exceeds IDX_W + OFS_W; the upper address bits are dropped.
module ramst_addr_split #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 7,
    parameter int OFS_W  = 3
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]  cell_idx,
    output logic [OFS_W-1:0]  cell_ofs
);
    localparam int TOP_LO = IDX_W + OFS_W;

    logic unused_hi;

    // Cut the address into its fields.
    always_comb begin
        cell_ofs  = byte_addr[OFS_W-1:0];
        cell_idx  = byte_addr[TOP_LO-1:OFS_W];
        unused_hi = ^byte_addr[ADDR_W-1:TOP_LO];
    end
endmodule

// File: rtl/ramst_lane_merge.sv
// Builds the value written back to a cell. The selected byte lanes take the
// new data and the other lanes keep the current cell value.
// Assumes CELL_W is a power of two and at least 32 bits; a word is four lanes.
module ramst_lane_merge
    import ramst_pkg::*;
#(
    parameter  int CELL_W = 64,
    localparam int LANES  = CELL_W / 8,
    localparam int OFS_W  = $clog2(LANES)
) (
    input  size_t             size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [CELL_W-1:0] cur,
    input  logic [CELL_W-1:0] din,
    output logic [CELL_W-1:0] merged,
    output logic              lane_any
);
    localparam int WORD_LANES = 4;

    logic [LANES-1:0] lane_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] new_byte;

        // Decide whether this lane is written and which byte it receives.
        always_comb begin
            unique case (size)
                SZ_DWORD: begin
                    lane_en[g] = 1'b1;
                    new_byte   = din[g*8 +: 8];
                end
                SZ_WORD: begin
                    lane_en[g] = ((ofs >> 2) == OFS_W'(g / WORD_LANES));
                    new_byte   = din[(g % WORD_LANES)*8 +: 8];
                end
                SZ_BYTE: begin
                    lane_en[g] = (ofs == OFS_W'(g));
                    new_byte   = din[7:0];
                end
                default: begin
                    lane_en[g] = 1'b0;
                    new_byte   = din[7:0];
                end
            endcase
        end

        // Choose between the new byte and the current one.
        always_comb merged[g*8 +: 8] = lane_en[g] ? new_byte : cur[g*8 +: 8];
    end

    // Report whether any lane is written.
    always_comb lane_any = |lane_en;
endmodule

// File: rtl/ramst_cell_array.sv
// The cell storage: a combinational read port and a single write port that
// writes on the rising edge. A synchronous reset clears every cell.
// Assumes read and write share an index within a cycle.
module ramst_cell_array #(
    parameter  int CELLS  = 128,
    parameter  int CELL_W = 64,
    localparam int IDX_W  = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [CELL_W-1:0] wr_data,
    output logic [CELL_W-1:0] rd_cell
);
    logic [CELL_W-1:0] mem [CELLS];

    // Clear on reset, otherwise write the whole cell when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    // Read the addressed cell without a clock.
    always_comb rd_cell = mem[idx];
endmodule

// File: rtl/dw_store_ram.sv
// Data memory of doubleword cells. Byte and word stores read the cell,
// merge the new lanes and write the result within one cycle.
// Assumes accesses never cross a cell boundary; sign extension is downstream.
module dw_store_ram
    import ramst_pkg::*;
#(
    parameter  int ADDR_W = 64,
    parameter  int CELLS  = 128,
    parameter  int CELL_W = 64,
    localparam int IDX_W  = $clog2(CELLS),
    localparam int OFS_W  = $clog2(CELL_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [CELL_W-1:0] st_data,
    input  logic              ld_en,
    input  logic              st_en,
    input  logic [1:0]        size_code,
    output logic [CELL_W-1:0] rd_data
);
    logic [IDX_W-1:0]  cell_idx;
    logic [OFS_W-1:0]  cell_ofs;
    logic [CELL_W-1:0] cur_cell;
    logic [CELL_W-1:0] merged;
    logic              lane_any;
    logic              wr_en;

    ramst_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_split (
        .byte_addr (byte_addr),
        .cell_idx  (cell_idx),
        .cell_ofs  (cell_ofs)
    );

    ramst_lane_merge #(.CELL_W(CELL_W)) u_merge (
        .size     (size_t'(size_code)),
        .ofs      (cell_ofs),
        .cur      (cur_cell),
        .din      (st_data),
        .merged   (merged),
        .lane_any (lane_any)
    );

    ramst_cell_array #(.CELLS(CELLS), .CELL_W(CELL_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (cell_idx),
        .wr_en   (wr_en),
        .wr_data (merged),
        .rd_cell (cur_cell)
    );

    // Write only for a store whose size code selects at least one lane.
    always_comb wr_en = st_en && lane_any;

    // Drive the load port, or zero when no load is requested.
    always_comb rd_data = ld_en ? cur_cell : '0;

    AST_DW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && size_code == 2'b11) |=> (!$stable(cell_idx) || cur_cell == $past(st_data))); // R3

    AST_WORD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && size_code == 2'b10) |=> (!$stable(cell_idx) || cur_cell == ($past(byte_addr[2]) ?
            {$past(st_data[31:0]), $past(cur_cell[31:0])} :
            {$past(cur_cell[63:32]), $past(st_data[31:0])}))); // R4

    AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && size_code == 2'b00) |=> (!$stable(cell_idx) ||
            ((cur_cell ^ $past(cur_cell)) & ~(64'hFF << {$past(byte_addr[2:0]), 3'b000})) == '0)); // R5

    AST_HALF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && size_code == 2'b01) |=> (!$stable(cell_idx) || $stable(cur_cell))); // R6

    AST_NO_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_en |=> (!$stable(cell_idx) || $stable(cur_cell))); // R7
endmodule

// File: tb/dw_store_ram_tb.sv
module dw_store_ram_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] byte_addr = '0;
    logic [63:0] st_data = '0;
    logic        ld_en = 1'b0;
    logic        st_en = 1'b0;
    logic [1:0]  size_code = 2'b11;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_mem [128];

    dw_store_ram u_dut (
        .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .st_data(st_data),
        .ld_en(ld_en), .st_en(st_en), .size_code(size_code), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] model_store(logic [63:0] cur, logic [2:0] ofs,
                                                logic [63:0] d, logic [1:0] sz);
        logic [63:0] r;
        r = cur;
        case (sz)
            2'b11: r = d;
            2'b10: r = ofs[2] ? {d[31:0], cur[31:0]} : {cur[63:32], d[31:0]};
            2'b00: r[ofs*8 +: 8] = d[7:0];
            default: r = cur;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; st_en = 1'b0; ld_en = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 128; i++) exp_mem[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one access, check the combinational read, then update the model.
    task automatic op(string req, logic [63:0] a, logic [63:0] d,
                      logic ld, logic st, logic [1:0] sz);
        logic [6:0] ix;
        @(negedge clk);
        byte_addr = a; st_data = d; ld_en = ld; st_en = st; size_code = sz;
        #1;
        ix = a[9:3];
        check(req, rd_data, ld ? exp_mem[ix] : 64'd0);
        @(posedge clk);
        if (st) exp_mem[ix] = model_store(exp_mem[ix], a[2:0], d, sz);
    endtask

    task automatic peek(string req, logic [63:0] a);
        op(req, a, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b0, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        // R1 reset state
        peek("R1", 64'h0); peek("R1", 64'h3F8); peek("R1", 64'h200);
        // R3 doubleword store, offset bits ignored
        op("R3", 64'h45, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, 2'b11);
        peek("R3", 64'h40);
        // R2 aliasing above bit 9
        peek("R2", 64'hFFFF_0000_0000_0440);
        op("R2", 64'h8000_0000_0000_0C48, 64'h1111_2222_3333_4444, 1'b0, 1'b1, 2'b11);
        peek("R2", 64'h48);
        // R4 both word halves
        op("R4", 64'h40, 64'hFFFF_FFFF_AAAA_5555, 1'b1, 1'b1, 2'b10);
        peek("R4", 64'h40);
        op("R4", 64'h44, 64'h0000_0000_7777_8888, 1'b1, 1'b1, 2'b10);
        peek("R4", 64'h40);
        // R5 every byte lane
        op("R3", 64'h80, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 2'b11);
        for (int n = 0; n < 8; n++) begin
            op("R5", 64'h80 + n, 64'hA0 + n, 1'b1, 1'b1, 2'b00);
            peek("R5", 64'h80);
        end
        // R6 unsupported size leaves the cell as it was
        op("R6", 64'h82, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1, 2'b01);
        peek("R6", 64'h80);
        // R7 store enable low
        op("R7", 64'h80, 64'h0, 1'b1, 1'b0, 2'b11);
        peek("R7", 64'h80);
        // R9 output gated, merge still uses stored cell
        op("R9", 64'h40, 64'h0, 1'b0, 1'b0, 2'b11);
        op("R9", 64'h43, 64'h5A, 1'b0, 1'b1, 2'b00);
        peek("R9", 64'h40);
        // R8 load and store in one cycle returns old data
        op("R8", 64'h40, 64'hCAFE_F00D_CAFE_F00D, 1'b1, 1'b1, 2'b11);
        peek("R8", 64'h40);
        // R1 reset clears written cells
        do_reset();
        peek("R1", 64'h40); peek("R1", 64'h80);
        // R8 random traffic over few cells
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            if ($urandom % 4 != 0) a[9:3] = 7'($urandom % 8);
            op("R8", a, {$urandom, $urandom}, 1'($urandom), 1'($urandom), 2'($urandom));
        end
        for (int c = 0; c < 8; c++) peek("R8", 64'(c * 8));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule